// File: doc/BRIEF.md
# Asynchronous Bus Batch Queue

This block holds single pending transactions for an asynchronous time-slot bus. Each transaction enters through the insert port with a 3-bit priority, a user tag and an estimated execution time in microseconds. The block stamps each accepted transaction with a free-running insertion number. Priority 0 is served first. Among transactions of equal priority, the lower insertion number goes first.

During the slot before an asynchronous slot, the bus controller pulses `prep_start`. The block then walks the queue in order and builds a batch whose execution times, plus one programmable overhead term, fit within a programmable slot budget. A transaction that would push the total past the budget is passed over, and the walk goes on to later, smaller transactions. The walk is short compared with a slot, so the batch is ready before the next time-code arrives.

The batch leaves through a valid/ready stream in queue order. Each transaction is removed from the queue as it is handed over. A one-cycle `done` pulse then reports how many transactions were taken. Transactions that were passed over stay in the queue with their priority and insertion number unchanged, so their relative order holds in later slots.

Top module: `async_batch_queue`

## Requirements
- R1: After reset the queue is empty: `full`, `busy`, `out_valid` and `done` are low, and the first accepted insert receives insertion number 0.
- R2: When `ins_valid` is high, the queue is not full and no batch is being prepared, `ins_accept` is high in the same cycle. The transaction is stored with the next insertion number, and the number increases by one per accepted insert.
- R3: With DEPTH transactions held, `full` is high, `ins_accept` stays low, and a transaction offered then is not stored.
- R4: While `busy` is high, an offered transaction is refused (`ins_accept` low) and does not appear in any later batch.
- R5: A batch is emitted in ascending priority (0 first) and, within a priority, in ascending insertion number.
- R6: The walk takes a transaction exactly when overhead + the times already taken in this batch + its own time is no more than the budget. Otherwise the transaction is skipped and the walk continues with the next one in order.
- R7: Skipped transactions remain queued with their original priority and insertion number, and the next batch visits them in the same relative order.
- R8: Each transaction handed over (`out_valid` and `out_ready` both high at a clock edge) is removed from the queue and is never emitted again.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_prio`, `out_tag`, `out_time` and `out_seq` hold their values.
- R10: After the walk ends, `done` is high for exactly one cycle with `done_count` equal to the number of transactions emitted. An empty queue, or an overhead larger than the budget, gives `done` with a count of 0.
- R11: With budget 1000 and overhead 0, the priority/number/time entries (0,0,600) (0,1,500) (1,2,125) (1,5,50) (2,3,150) (3,4,300) (3,7,100) (5,6,90) give the batch with numbers 0, 2, 5, 3. A second batch then gives 1, 4, 7, 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_prio | input | 3 | Priority of the offered transaction, 0 highest |
| ins_tag | input | TAG_W | User tag of the offered transaction |
| ins_time | input | TIME_W | Estimated execution time in microseconds |
| ins_accept | output | 1 | Offered transaction stored this cycle |
| full | output | 1 | All DEPTH entries are occupied |
| cfg_budget | input | SUM_W | Slot budget in microseconds |
| cfg_overhead | input | SUM_W | Fixed overhead added once per batch |
| prep_start | input | 1 | Start preparing a batch (taken when idle) |
| busy | output | 1 | Batch preparation in progress |
| out_valid | output | 1 | Batch entry presented |
| out_ready | input | 1 | Consumer accepts the presented entry |
| out_prio | output | 3 | Priority of the presented entry |
| out_tag | output | TAG_W | Tag of the presented entry |
| out_time | output | TIME_W | Execution time of the presented entry |
| out_seq | output | SEQ_W | Insertion number of the presented entry |
| done | output | 1 | One-cycle pulse: batch complete |
| done_count | output | $clog2(DEPTH+1) | Entries in the completed batch |

## Verification
The checker assumes that `cfg_budget` and `cfg_overhead` stay constant from `prep_start` until `done`, and that fewer than 2^SEQ_W transactions are inserted, so insertion numbers never wrap. Under these assumptions its accumulated-time and strict-ordering properties are sound. The stimulus changes the configuration only between batches and inserts a few hundred transactions in total. It pulses `prep_start` only while idle, and it offers inserts during a batch only to probe the refusal.

// File: rtl/abq_pkg.sv
package abq_pkg;
   localparam int PRIO_W = 3;

   typedef enum logic [1:0] {
      ABQ_IDLE = 2'd0,
      ABQ_SCAN = 2'd1,
      ABQ_EMIT = 2'd2
   } abq_state_e;
endpackage

// File: rtl/abq_store.sv
module abq_store
   import abq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int TAG_W  = 8,
   parameter int TIME_W = 12,
   parameter int SEQ_W  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [PRIO_W-1:0]         wr_prio,
   input  logic [TAG_W-1:0]          wr_tag,
   input  logic [TIME_W-1:0]         wr_time,
   input  logic [SEQ_W-1:0]          wr_seq,
   input  logic                      clr_en,
   input  logic [IDX_W-1:0]          clr_idx,
   output logic [DEPTH-1:0]          occ,
   output logic [DEPTH*PRIO_W-1:0]   prio_flat,
   output logic [DEPTH*TAG_W-1:0]    tag_flat,
   output logic [DEPTH*TIME_W-1:0]   time_flat,
   output logic [DEPTH*SEQ_W-1:0]    seq_flat,
   output logic                      full
);
   logic [IDX_W-1:0] free_idx;

   // lowest-numbered free slot receives the next insert
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!occ[i]) free_idx = IDX_W'(i);
      end
   end

   assign full = &occ;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic wr_here;
      logic clr_here;
      assign wr_here  = wr_en && !full && (free_idx == IDX_W'(g));
      assign clr_here = clr_en && (clr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            occ[g]                          <= 1'b0;
            prio_flat[g*PRIO_W +: PRIO_W]   <= '0;
            tag_flat[g*TAG_W +: TAG_W]      <= '0;
            time_flat[g*TIME_W +: TIME_W]   <= '0;
            seq_flat[g*SEQ_W +: SEQ_W]      <= '0;
         end else if (wr_here) begin
            occ[g]                          <= 1'b1;
            prio_flat[g*PRIO_W +: PRIO_W]   <= wr_prio;
            tag_flat[g*TAG_W +: TAG_W]      <= wr_tag;
            time_flat[g*TIME_W +: TIME_W]   <= wr_time;
            seq_flat[g*SEQ_W +: SEQ_W]      <= wr_seq;
         end else if (clr_here) begin
            occ[g]                          <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/abq_minsel.sv
module abq_minsel
   import abq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]        cand,
   input  logic [DEPTH*PRIO_W-1:0] prio_flat,
   input  logic [DEPTH*SEQ_W-1:0]  seq_flat,
   output logic                    found,
   output logic [IDX_W-1:0]        idx
);
   logic [PRIO_W-1:0] best_p;
   logic [SEQ_W-1:0]  best_s;

   // smallest (priority, insertion number) key among candidates
   always_comb begin
      found  = 1'b0;
      idx    = '0;
      best_p = '0;
      best_s = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand[i] && (!found ||
             (prio_flat[i*PRIO_W +: PRIO_W] < best_p) ||
             ((prio_flat[i*PRIO_W +: PRIO_W] == best_p) &&
              (seq_flat[i*SEQ_W +: SEQ_W] < best_s)))) begin
            found  = 1'b1;
            idx    = IDX_W'(i);
            best_p = prio_flat[i*PRIO_W +: PRIO_W];
            best_s = seq_flat[i*SEQ_W +: SEQ_W];
         end
      end
   end
endmodule

// File: rtl/abq_ctrl.sv
module abq_ctrl
   import abq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int TIME_W = 12,
   parameter int SUM_W  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SUM_W-1:0]  budget,
   input  logic [SUM_W-1:0]  overhead,
   input  logic [DEPTH-1:0]  occ,
   input  logic              sel_found,
   input  logic [IDX_W-1:0]  sel_idx,
   input  logic [TIME_W-1:0] sel_time,
   input  logic [TIME_W-1:0] cur_time,
   input  logic              out_ready,
   output logic [DEPTH-1:0]  cand,
   output logic              busy,
   output logic              emit,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              clr_en,
   output logic              done,
   output logic [CNT_W-1:0]  done_count
);
   abq_state_e       state_q;
   logic [DEPTH-1:0] visited_q;
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W-1:0] budget_q;
   logic [CNT_W-1:0] count_q;
   logic             fits;

   assign cand   = occ & ~visited_q;
   assign busy   = (state_q != ABQ_IDLE);
   assign emit   = (state_q == ABQ_EMIT);
   assign clr_en = emit && out_ready;
   assign fits   = ({1'b0, sum_q} + (SUM_W + 1)'(sel_time)) <= {1'b0, budget_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ABQ_IDLE;
         visited_q  <= '0;
         sum_q      <= '0;
         budget_q   <= '0;
         count_q    <= '0;
         cur_idx    <= '0;
         done       <= 1'b0;
         done_count <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ABQ_IDLE: begin
               if (start) begin
                  visited_q <= '0;
                  sum_q     <= overhead;
                  budget_q  <= budget;
                  count_q   <= '0;
                  state_q   <= ABQ_SCAN;
               end
            end
            ABQ_SCAN: begin
               if (!sel_found) begin
                  done       <= 1'b1;
                  done_count <= count_q;
                  state_q    <= ABQ_IDLE;
               end else if (fits) begin
                  cur_idx <= sel_idx;
                  state_q <= ABQ_EMIT;
               end else begin
                  visited_q[sel_idx] <= 1'b1;
               end
            end
            ABQ_EMIT: begin
               if (out_ready) begin
                  sum_q   <= sum_q + SUM_W'(cur_time);
                  count_q <= count_q + 1'b1;
                  state_q <= ABQ_SCAN;
               end
            end
            default: state_q <= ABQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/async_batch_queue.sv
module async_batch_queue
   import abq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int TAG_W  = 8,
   parameter int TIME_W = 12,
   parameter int SUM_W  = 16,
   parameter int SEQ_W  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [2:0]        ins_prio,
   input  logic [TAG_W-1:0]  ins_tag,
   input  logic [TIME_W-1:0] ins_time,
   output logic              ins_accept,
   output logic              full,
   input  logic [SUM_W-1:0]  cfg_budget,
   input  logic [SUM_W-1:0]  cfg_overhead,
   input  logic              prep_start,
   output logic              busy,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [2:0]        out_prio,
   output logic [TAG_W-1:0]  out_tag,
   output logic [TIME_W-1:0] out_time,
   output logic [SEQ_W-1:0]  out_seq,
   output logic              done,
   output logic [CNT_W-1:0]  done_count
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("async_batch_queue: DEPTH must be at least 2");
   end
   if (SUM_W < TIME_W) begin : g_bad_sum
      $error("async_batch_queue: SUM_W must not be narrower than TIME_W");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("async_batch_queue: SEQ_W must be at least 2");
   end

   logic [DEPTH-1:0]        occ;
   logic [DEPTH-1:0]        cand;
   logic [DEPTH*PRIO_W-1:0] prio_flat;
   logic [DEPTH*TAG_W-1:0]  tag_flat;
   logic [DEPTH*TIME_W-1:0] time_flat;
   logic [DEPTH*SEQ_W-1:0]  seq_flat;
   logic                    sel_found;
   logic [IDX_W-1:0]        sel_idx;
   logic [IDX_W-1:0]        cur_idx;
   logic                    clr_en;
   logic [SEQ_W-1:0]        seq_q;

   assign ins_accept = ins_valid && !full && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seq_q <= '0;
      else if (ins_accept) seq_q <= seq_q + 1'b1;
   end

   abq_store #(
      .DEPTH(DEPTH), .TAG_W(TAG_W), .TIME_W(TIME_W), .SEQ_W(SEQ_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ins_accept), .wr_prio(ins_prio), .wr_tag(ins_tag),
      .wr_time(ins_time), .wr_seq(seq_q),
      .clr_en(clr_en), .clr_idx(cur_idx),
      .occ(occ), .prio_flat(prio_flat), .tag_flat(tag_flat),
      .time_flat(time_flat), .seq_flat(seq_flat), .full(full)
   );

   abq_minsel #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W)
   ) u_minsel (
      .cand(cand), .prio_flat(prio_flat), .seq_flat(seq_flat),
      .found(sel_found), .idx(sel_idx)
   );

   abq_ctrl #(
      .DEPTH(DEPTH), .TIME_W(TIME_W), .SUM_W(SUM_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(prep_start),
      .budget(cfg_budget), .overhead(cfg_overhead),
      .occ(occ), .sel_found(sel_found), .sel_idx(sel_idx),
      .sel_time(time_flat[sel_idx*TIME_W +: TIME_W]),
      .cur_time(time_flat[cur_idx*TIME_W +: TIME_W]),
      .out_ready(out_ready), .cand(cand), .busy(busy), .emit(out_valid),
      .cur_idx(cur_idx), .clr_en(clr_en), .done(done), .done_count(done_count)
   );

   assign out_prio = prio_flat[cur_idx*PRIO_W +: PRIO_W];
   assign out_tag  = tag_flat[cur_idx*TAG_W +: TAG_W];
   assign out_time = time_flat[cur_idx*TIME_W +: TIME_W];
   assign out_seq  = seq_flat[cur_idx*SEQ_W +: SEQ_W];
endmodule

// File: rtl/async_batch_queue_chk.sv
module async_batch_queue_chk #(
   parameter int DEPTH  = 16,
   parameter int TAG_W  = 8,
   parameter int TIME_W = 12,
   parameter int SUM_W  = 16,
   parameter int SEQ_W  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ins_valid,
   input logic              ins_accept,
   input logic              full,
   input logic [SUM_W-1:0]  cfg_budget,
   input logic [SUM_W-1:0]  cfg_overhead,
   input logic              prep_start,
   input logic              busy,
   input logic              out_valid,
   input logic              out_ready,
   input logic [2:0]        out_prio,
   input logic [TAG_W-1:0]  out_tag,
   input logic [TIME_W-1:0] out_time,
   input logic [SEQ_W-1:0]  out_seq,
   input logic              done,
   input logic [CNT_W-1:0]  done_count
);
   logic [SUM_W+1:0]   acc_q;
   logic [CNT_W-1:0]   emit_q;
   logic               have_last_q;
   logic [2:0]         last_p_q;
   logic [SEQ_W-1:0]   last_s_q;
   logic               hs;

   assign hs = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q       <= '0;
         emit_q      <= '0;
         have_last_q <= 1'b0;
         last_p_q    <= '0;
         last_s_q    <= '0;
      end else if (!busy && prep_start) begin
         acc_q       <= '0;
         emit_q      <= '0;
         have_last_q <= 1'b0;
      end else if (hs) begin
         acc_q       <= acc_q + (SUM_W + 2)'(out_time);
         emit_q      <= emit_q + 1'b1;
         have_last_q <= 1'b1;
         last_p_q    <= out_prio;
         last_s_q    <= out_seq;
      end
   end

   p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !ins_accept);

   p_busy_refuses_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ins_valid) |-> !ins_accept);

   p_batch_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && have_last_q) |-> ({out_prio, out_seq} > {last_p_q, last_s_q}));

   p_within_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hs |-> ((acc_q + (SUM_W + 2)'(out_time) + (SUM_W + 2)'(cfg_overhead))
              <= (SUM_W + 2)'(cfg_budget)));

   p_hold_when_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) &&
                                     $stable(out_seq) && $stable(out_time) &&
                                     $stable(out_prio)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_count == emit_q && !out_valid && !busy));
endmodule

bind async_batch_queue async_batch_queue_chk #(
   .DEPTH(DEPTH), .TAG_W(TAG_W), .TIME_W(TIME_W), .SUM_W(SUM_W), .SEQ_W(SEQ_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_accept(ins_accept),
   .full(full), .cfg_budget(cfg_budget), .cfg_overhead(cfg_overhead),
   .prep_start(prep_start), .busy(busy), .out_valid(out_valid),
   .out_ready(out_ready), .out_prio(out_prio), .out_tag(out_tag),
   .out_time(out_time), .out_seq(out_seq), .done(done), .done_count(done_count)
);

// File: tb/async_batch_queue_bench.sv
`timescale 1ns/1ps
module async_batch_queue_bench;
   localparam int DEPTH  = 16;
   localparam int TAG_W  = 8;
   localparam int TIME_W = 12;
   localparam int SUM_W  = 16;
   localparam int SEQ_W  = 16;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ins_valid = 1'b0;
   logic [2:0]        ins_prio = '0;
   logic [TAG_W-1:0]  ins_tag = '0;
   logic [TIME_W-1:0] ins_time = '0;
   logic              ins_accept;
   logic              full;
   logic [SUM_W-1:0]  cfg_budget = '0;
   logic [SUM_W-1:0]  cfg_overhead = '0;
   logic              prep_start = 1'b0;
   logic              busy;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [2:0]        out_prio;
   logic [TAG_W-1:0]  out_tag;
   logic [TIME_W-1:0] out_time;
   logic [SEQ_W-1:0]  out_seq;
   logic              done;
   logic [CNT_W-1:0]  done_count;

   always #5 clk = ~clk;

   async_batch_queue #(
      .DEPTH(DEPTH), .TAG_W(TAG_W), .TIME_W(TIME_W), .SUM_W(SUM_W), .SEQ_W(SEQ_W)
   ) u_async_batch_queue (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_prio(ins_prio),
      .ins_tag(ins_tag), .ins_time(ins_time), .ins_accept(ins_accept),
      .full(full), .cfg_budget(cfg_budget), .cfg_overhead(cfg_overhead),
      .prep_start(prep_start), .busy(busy), .out_valid(out_valid),
      .out_ready(out_ready), .out_prio(out_prio), .out_tag(out_tag),
      .out_time(out_time), .out_seq(out_seq), .done(done), .done_count(done_count)
   );

   int n_checks = 0;
   int n_fail = 0;

   // model of the queue contents
   bit m_valid [DEPTH];
   int m_prio  [DEPTH];
   int m_seq   [DEPTH];
   int m_tag   [DEPTH];
   int m_time  [DEPTH];
   int next_seq = 0;
   int exp_idx [DEPTH];
   int exp_n;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   function automatic int model_count();
      int c = 0;
      for (int i = 0; i < DEPTH; i++) if (m_valid[i]) c++;
      return c;
   endfunction

   // expected batch from the ordering and budget rules
   function automatic void plan_batch(input int budget, input int ovh);
      bit seen [DEPTH];
      int sum = ovh;
      exp_n = 0;
      for (int i = 0; i < DEPTH; i++) seen[i] = 1'b0;
      forever begin
         int best = -1;
         for (int i = 0; i < DEPTH; i++) begin
            if (m_valid[i] && !seen[i]) begin
               if (best < 0 || m_prio[i] < m_prio[best] ||
                   (m_prio[i] == m_prio[best] && m_seq[i] < m_seq[best]))
                  best = i;
            end
         end
         if (best < 0) break;
         seen[best] = 1'b1;
         if (sum + m_time[best] <= budget) begin
            sum += m_time[best];
            exp_idx[exp_n] = best;
            exp_n++;
         end
      end
   endfunction

   task automatic do_insert(input int prio, input int tag, input int tm);
      bit exp_acc;
      exp_acc = (model_count() < DEPTH);
      ins_prio  = 3'(prio);
      ins_tag   = TAG_W'(tag);
      ins_time  = TIME_W'(tm);
      ins_valid = 1'b1;
      #1;
      check(ins_accept == exp_acc, exp_acc ? "R2" : "R3", "ins_accept",
            int'(ins_accept), int'(exp_acc));
      @(negedge clk);
      ins_valid = 1'b0;
      if (exp_acc) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (!m_valid[i]) begin
               m_valid[i] = 1'b1;
               m_prio[i]  = prio;
               m_seq[i]   = next_seq;
               m_tag[i]   = tag;
               m_time[i]  = tm;
               break;
            end
         end
         next_seq++;
      end
      check(full == (model_count() == DEPTH), "R3", "full flag",
            int'(full), int'(model_count() == DEPTH));
   endtask

   task automatic run_batch(input int budget, input int ovh, input bit stall,
                            input bit poke, input string req);
      int k = 0;
      int guard = 0;
      plan_batch(budget, ovh);
      cfg_budget   = SUM_W'(budget);
      cfg_overhead = SUM_W'(ovh);
      prep_start   = 1'b1;
      @(negedge clk);
      prep_start   = 1'b0;
      if (poke) begin
         ins_valid = 1'b1;
         ins_prio  = 3'd0;
         ins_tag   = 8'hEE;
         ins_time  = 12'd1;
         #1;
         check(ins_accept == 1'b0, "R4", "insert while busy", int'(ins_accept), 0);
         ins_valid = 1'b0;
      end
      forever begin
         if (done) begin
            check(done_count == CNT_W'(exp_n), "R10", "done_count",
                  int'(done_count), exp_n);
            check(k == exp_n, "R10", "entries emitted before done", k, exp_n);
            out_ready = 1'b0;
            break;
         end
         if (out_valid) begin
            if (k >= exp_n) begin
               check(1'b0, req, "extra batch entry seq", int'(out_seq), -1);
               out_ready = 1'b1;
            end else begin
               int e = exp_idx[k];
               check(out_seq == SEQ_W'(m_seq[e]), req, "out_seq",
                     int'(out_seq), m_seq[e]);
               check(out_tag == TAG_W'(m_tag[e]) && out_prio == 3'(m_prio[e]) &&
                     out_time == TIME_W'(m_time[e]), out_ready ? req : "R9",
                     "out_tag", int'(out_tag), m_tag[e]);
               out_ready = stall ? 1'($urandom % 2) : 1'b1;
               if (out_ready) k++;
            end
         end else begin
            out_ready = 1'b0;
         end
         guard++;
         if (guard > 2000) begin
            check(1'b0, "R10", "done never seen", 0, 1);
            break;
         end
         @(negedge clk);
      end
      for (int j = 0; j < exp_n; j++) m_valid[exp_idx[j]] = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0A51));
      for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!full && !busy && !out_valid && !done, "R1", "idle after reset",
            int'({full, busy, out_valid, done}), 0);

      // R11 worked example: insertion numbers follow insertion order
      do_insert(0, 0, 600); do_insert(0, 1, 500); do_insert(1, 2, 125);
      do_insert(2, 3, 150); do_insert(3, 4, 300); do_insert(1, 5, 50);
      do_insert(5, 6, 90);  do_insert(3, 7, 100);
      run_batch(1000, 0, 1'b0, 1'b1, "R11");
      check(exp_n == 4 && m_seq[exp_idx[0]] == 0 && m_seq[exp_idx[1]] == 2 &&
            m_seq[exp_idx[2]] == 5 && m_seq[exp_idx[3]] == 3, "R11",
            "model batch size", exp_n, 4);
      // R7: the skipped entry leads the next batch
      run_batch(1000, 0, 1'b1, 1'b0, "R7");
      check(model_count() == 0, "R8", "queue drained", model_count(), 0);
      // R10: empty queue
      run_batch(1000, 0, 1'b0, 1'b0, "R10");
      // R3: fill to capacity, then one more
      for (int i = 0; i < DEPTH + 1; i++) do_insert(i % 8, 16 + i, 40 + i);
      // R6: overhead above budget takes nothing
      run_batch(100, 200, 1'b0, 1'b0, "R6");
      // R6: tight budget forces skips
      run_batch(180, 30, 1'b1, 1'b0, "R6");
      run_batch(4000, 0, 1'b0, 1'b0, "R5");

      // random phase
      for (int r = 0; r < 60; r++) begin
         int n_ins = $urandom % 7;
         for (int j = 0; j < n_ins; j++)
            do_insert($urandom % 8, $urandom % 256, 1 + $urandom % 400);
         run_batch(300 + $urandom % 1200, $urandom % 100, 1'($urandom % 2),
                   1'($urandom % 2), "R5");
      end
      run_batch(60000, 0, 1'b1, 1'b0, "R8");
      check(model_count() == 0, "R8", "final drain", model_count(), 0);
      finish_run();
   end
endmodule